// File: doc/BRIEF.md
# Multi-Mode Line Serializer/Deserializer Datapath

This block sits between a one-bit serial line stream and a framer. The framer side can run in one of three modes, chosen at run time. In bit mode, single bits cross the block at line rate. In narrow-word mode, 4-bit words are used. In wide-word mode, 8-bit words are used. On the receive side, line bits are gathered into words with the earliest bit in the top active lane. On the transmit side, framer words are sampled and sent out top lane first. A divided word clock and a one-cycle word strobe mark the word boundaries. Everything runs in one line-rate clock domain, and the recovered line clock is modelled as that clock.

Two loopback paths are provided. Remote loopback sends the received line data back out of the transmitter in place of framer data. Local loopback feeds the transmitted line bit into the receiver in place of the line input. Local loopback is allowed only when the block runs from its local reference and remote loopback is off. A reference-select output tells the clocking logic whether to use the local reference or the recovered receive clock.

Top module: `line_serdes_mux`

## Requirements
- R1: With `par_sel` low (bit mode), `line_tx_bit` equals `fr_tx_bit` from one cycle earlier and `fr_rx_bit` equals the receive input from one cycle earlier. `word_stb` is high in every cycle and `fr_rx_word` is zero. Changing `wide_sel` in bit mode causes no clear: `word_valid` stays high.
- R2: With `par_sel` high, `word_clk` has a period of N cycles with a 50% duty cycle (N = 8 when `wide_sel` is high, N = 4 when it is low). It is low in the first N/2 cycles of each word and high in the last N/2. In bit mode `word_clk` is low.
- R3: In word modes, the first of N received bits lands in `fr_rx_word[N-1]` and the last in bit 0. The word appears on `fr_rx_word` in the cycle after its last bit was sampled. `word_stb` is high for that one cycle only.
- R4: In narrow-word mode, `fr_rx_word[7:4]` is always zero and `fr_tx_word[7:4]` has no effect on the line output.
- R5: `fr_tx_word` is sampled at the same edge that updates `fr_rx_word`. In the following N cycles, `line_tx_bit` carries the active lanes from bit N-1 down to bit 0, one per cycle.
- R6: With `rmt_loop` high, the transmitter sends the received data and ignores the framer data. In bit mode, `line_tx_bit` is `line_rx_bit` delayed by one cycle. In word modes, each received word is sent out during the following word.
- R7: With `lcl_loop` high, `hub_sel` high and `rmt_loop` low, the receiver takes `line_tx_bit` instead of `line_rx_bit`. If `hub_sel` is low or `rmt_loop` is high, `lcl_loop` has no effect.
- R8: `ref_sel_local` is high only when `hub_sel` is high and `rmt_loop` is low. `lcl_loop` does not affect it.
- R9: A change of `par_sel`, or of `wide_sel` while `par_sel` is high, clears the bit counter, both shift registers, `fr_rx_word`, `word_stb` and `word_valid` at the next edge. The first word after the clear transmits zeros. `word_valid` rises with the first word completed after the clear.
- R10: While `rst_n` is low, `line_tx_bit`, `fr_rx_bit`, `fr_rx_word`, `word_clk`, `word_stb`, `word_valid` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-rate clock (recovered clock model) |
| rst_n | input | 1 | Active-low synchronous reset |
| par_sel | input | 1 | 1 = word modes, 0 = bit mode |
| wide_sel | input | 1 | In word modes: 1 = 8-bit, 0 = 4-bit |
| hub_sel | input | 1 | 1 = local reference, 0 = recovered reference |
| rmt_loop | input | 1 | Remote loopback enable |
| lcl_loop | input | 1 | Local loopback request |
| fr_tx_bit | input | 1 | Framer transmit bit (bit mode) |
| fr_tx_word | input | 8 | Framer transmit word (word modes) |
| line_rx_bit | input | 1 | Serial bit from the line |
| line_tx_bit | output | 1 | Serial bit to the line |
| fr_rx_bit | output | 1 | Framer receive bit (bit mode) |
| fr_rx_word | output | 8 | Framer receive word (word modes) |
| word_clk | output | 1 | Divided word clock |
| word_stb | output | 1 | One-cycle word boundary strobe |
| word_valid | output | 1 | A full word has completed since the last clear |
| ref_sel_local | output | 1 | 1 = use local reference clock |

## Verification
A table of words runs through both word modes, sending the same framer word and line word in each cycle of the word. The words are chosen so that the patterns tell them apart:
- Single-bit patterns (01, 80) show whether the bit order is reversed.
- All-ones and all-zeros patterns show a stuck lane.
- Narrow-mode patterns have non-zero upper nibbles, so leakage from the upper lanes is visible on both paths.

In bit mode, the framer bit and the line bit follow different sequences, so swapped routing is visible. The loopback cases use a toggling line stream with framer data held at its complement. Because of this, a looped path and a direct path give different values one cycle apart. A mode switch in the middle of a word shows whether the clear is complete: receive words, the valid flag and the queued transmit word must all be reset.

// File: rtl/lsd_pkg.sv
package lsd_pkg;
   typedef enum logic [1:0] {
      LM_SER    = 2'b00,
      LM_NARROW = 2'b10,
      LM_WIDE   = 2'b11
   } lane_mode_e;

   function automatic lane_mode_e decode_mode(input logic par, input logic wide);
      if (!par)     return LM_SER;
      else if (wide) return LM_WIDE;
      else          return LM_NARROW;
   endfunction
endpackage

// File: rtl/lsd_lane_mask.sv
module lsd_lane_mask
   import lsd_pkg::*;
#(
   parameter int WORD_W   = 8,
   parameter int NARROW_W = 4
) (
   input  lane_mode_e        mode_i,
   output logic [WORD_W-1:0] en_o
);
   for (genvar i = 0; i < WORD_W; i++) begin : g_lane
      if (i < NARROW_W) begin : g_low
         assign en_o[i] = (mode_i != LM_SER);
      end else begin : g_high
         assign en_o[i] = (mode_i == LM_WIDE);
      end
   end
endmodule

// File: rtl/lsd_ctrl.sv
module lsd_ctrl
   import lsd_pkg::*;
#(
   parameter int WORD_W   = 8,
   parameter int NARROW_W = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       par_sel,
   input  logic       wide_sel,
   input  logic       hub_sel,
   input  logic       rmt_loop,
   input  logic       lcl_loop,
   output lane_mode_e mode_o,
   output logic       clear_o,
   output logic       last_o,
   output logic       word_clk_o,
   output logic       word_stb_o,
   output logic       word_valid_o,
   output logic       lcl_on_o,
   output logic       ref_local_o
);
   localparam int CNT_W = $clog2(WORD_W);

   lane_mode_e         mode_now;
   lane_mode_e         mode_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [CNT_W:0]     act_w;
   logic [CNT_W:0]     cnt_ext;

   assign mode_now = decode_mode(par_sel, wide_sel);
   assign clear_o  = (mode_now != mode_q);
   assign mode_o   = mode_q;
   assign cnt_ext  = {1'b0, cnt_q};

   always_comb begin
      case (mode_q)
         LM_WIDE:   act_w = (CNT_W+1)'(WORD_W);
         LM_NARROW: act_w = (CNT_W+1)'(NARROW_W);
         default:   act_w = (CNT_W+1)'(1);
      endcase
   end

   assign last_o     = !clear_o && (cnt_ext == act_w - 1'b1);
   assign word_clk_o = (mode_q != LM_SER) && (cnt_ext >= (act_w >> 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q       <= LM_SER;
         cnt_q        <= '0;
         word_stb_o   <= 1'b0;
         word_valid_o <= 1'b0;
      end else begin
         mode_q <= mode_now;
         if (clear_o || last_o) cnt_q <= '0;
         else                   cnt_q <= cnt_q + 1'b1;
         word_stb_o <= last_o;
         if (clear_o)     word_valid_o <= 1'b0;
         else if (last_o) word_valid_o <= 1'b1;
      end
   end

   assign lcl_on_o    = lcl_loop && hub_sel && !rmt_loop;
   assign ref_local_o = hub_sel && !rmt_loop;
endmodule

// File: rtl/lsd_rx.sv
module lsd_rx
   import lsd_pkg::*;
#(
   parameter int WORD_W   = 8,
   parameter int NARROW_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  lane_mode_e        mode_i,
   input  logic              clear_i,
   input  logic              last_i,
   input  logic              rx_in,
   output logic [WORD_W-1:0] asm_o,
   output logic [WORD_W-1:0] rx_word_o,
   output logic              rx_bit_o
);
   logic [WORD_W-2:0] sh_q;
   logic [WORD_W-1:0] lane_en;

   lsd_lane_mask #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_mask (
      .mode_i (mode_i),
      .en_o   (lane_en)
   );

   assign asm_o = {sh_q, rx_in} & lane_en;

   always_ff @(posedge clk) begin
      if (!rst_n || clear_i) begin
         sh_q      <= '0;
         rx_word_o <= '0;
         rx_bit_o  <= 1'b0;
      end else begin
         sh_q     <= {sh_q[WORD_W-3:0], rx_in};
         rx_bit_o <= (mode_i == LM_SER) ? rx_in : 1'b0;
         if (last_i && (mode_i != LM_SER)) rx_word_o <= asm_o;
      end
   end
endmodule

// File: rtl/lsd_tx.sv
module lsd_tx
   import lsd_pkg::*;
#(
   parameter int WORD_W   = 8,
   parameter int NARROW_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  lane_mode_e        mode_i,
   input  logic              clear_i,
   input  logic              last_i,
   input  logic              src_bit_i,
   input  logic [WORD_W-1:0] src_word_i,
   output logic              line_bit_o
);
   localparam int CNT_W = $clog2(WORD_W);

   logic [WORD_W-1:0] sh_q;
   logic [WORD_W-1:0] lane_en;
   logic [CNT_W-1:0]  top_idx;

   lsd_lane_mask #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_mask (
      .mode_i (mode_i),
      .en_o   (lane_en)
   );

   assign top_idx = (mode_i == LM_WIDE) ? CNT_W'(WORD_W - 1) : CNT_W'(NARROW_W - 1);

   always_ff @(posedge clk) begin
      if (!rst_n || clear_i) begin
         sh_q       <= '0;
         line_bit_o <= 1'b0;
      end else if (mode_i == LM_SER) begin
         sh_q       <= '0;
         line_bit_o <= src_bit_i;
      end else begin
         line_bit_o <= sh_q[top_idx];
         if (last_i) sh_q <= src_word_i & lane_en;
         else        sh_q <= sh_q << 1;
      end
   end
endmodule

// File: rtl/line_serdes_mux.sv
module line_serdes_mux
   import lsd_pkg::*;
#(
   parameter int WORD_W   = 8,
   parameter int NARROW_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              par_sel,
   input  logic              wide_sel,
   input  logic              hub_sel,
   input  logic              rmt_loop,
   input  logic              lcl_loop,
   input  logic              fr_tx_bit,
   input  logic [WORD_W-1:0] fr_tx_word,
   input  logic              line_rx_bit,
   output logic              line_tx_bit,
   output logic              fr_rx_bit,
   output logic [WORD_W-1:0] fr_rx_word,
   output logic              word_clk,
   output logic              word_stb,
   output logic              word_valid,
   output logic              ref_sel_local
);
   if (WORD_W < 3 || NARROW_W < 2 || NARROW_W >= WORD_W ||
       (WORD_W % 2) != 0 || (NARROW_W % 2) != 0) begin : g_bad_cfg
      $error("line_serdes_mux: widths must be even with 2 <= NARROW_W < WORD_W");
   end

   lane_mode_e        mode;
   logic              clear;
   logic              last;
   logic              lcl_on;
   logic              rx_in;
   logic              tx_src_bit;
   logic [WORD_W-1:0] rx_asm;
   logic [WORD_W-1:0] tx_src_word;

   lsd_ctrl #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .par_sel      (par_sel),
      .wide_sel     (wide_sel),
      .hub_sel      (hub_sel),
      .rmt_loop     (rmt_loop),
      .lcl_loop     (lcl_loop),
      .mode_o       (mode),
      .clear_o      (clear),
      .last_o       (last),
      .word_clk_o   (word_clk),
      .word_stb_o   (word_stb),
      .word_valid_o (word_valid),
      .lcl_on_o     (lcl_on),
      .ref_local_o  (ref_sel_local)
   );

   assign rx_in       = lcl_on ? line_tx_bit : line_rx_bit;
   assign tx_src_bit  = rmt_loop ? rx_in : fr_tx_bit;
   assign tx_src_word = rmt_loop ? rx_asm : fr_tx_word;

   lsd_rx #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_i    (mode),
      .clear_i   (clear),
      .last_i    (last),
      .rx_in     (rx_in),
      .asm_o     (rx_asm),
      .rx_word_o (fr_rx_word),
      .rx_bit_o  (fr_rx_bit)
   );

   lsd_tx #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_i     (mode),
      .clear_i    (clear),
      .last_i     (last),
      .src_bit_i  (tx_src_bit),
      .src_word_i (tx_src_word),
      .line_bit_o (line_tx_bit)
   );
endmodule

// File: rtl/lsd_checker.sv
module lsd_checker #(
   parameter int WORD_W   = 8,
   parameter int NARROW_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              par_sel,
   input logic              wide_sel,
   input logic              hub_sel,
   input logic              rmt_loop,
   input logic              fr_tx_bit,
   input logic              line_rx_bit,
   input logic              line_tx_bit,
   input logic              fr_rx_bit,
   input logic [WORD_W-1:0] fr_rx_word,
   input logic              word_clk,
   input logic              word_stb,
   input logic              word_valid,
   input logic              ref_sel_local
);
   p_ser_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!par_sel && $past(!par_sel) && $past(rst_n) && !rmt_loop)
      |=> (line_tx_bit == $past(fr_tx_bit)));

   p_ser_wclk_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!par_sel && $past(!par_sel) && $past(rst_n)) |-> !word_clk);

   p_stb_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (par_sel && $past(par_sel) && $past(rst_n) && word_stb) |-> !$past(word_stb));

   p_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (par_sel && !wide_sel && $past(par_sel && !wide_sel))
      |-> ((fr_rx_word >> NARROW_W) == '0));

   p_rmt_ser_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!par_sel && $past(!par_sel) && $past(rst_n) && rmt_loop)
      |=> (line_tx_bit == $past(line_rx_bit)));

   p_lcl_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!par_sel && $past(!par_sel) && $past(rst_n) && (!hub_sel || rmt_loop))
      |=> (fr_rx_bit == $past(line_rx_bit)));

   p_ref_rmt_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rmt_loop || !hub_sel) |-> !ref_sel_local);

   p_chg_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && (par_sel != $past(par_sel)))
      |=> (!word_valid && !word_stb && fr_rx_word == '0));
endmodule

bind line_serdes_mux lsd_checker #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .par_sel       (par_sel),
   .wide_sel      (wide_sel),
   .hub_sel       (hub_sel),
   .rmt_loop      (rmt_loop),
   .fr_tx_bit     (fr_tx_bit),
   .line_rx_bit   (line_rx_bit),
   .line_tx_bit   (line_tx_bit),
   .fr_rx_bit     (fr_rx_bit),
   .fr_rx_word    (fr_rx_word),
   .word_clk      (word_clk),
   .word_stb      (word_stb),
   .word_valid    (word_valid),
   .ref_sel_local (ref_sel_local)
);

// File: tb/sim_line_serdes_mux.sv
module sim_line_serdes_mux;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic       rst_n, par_sel, wide_sel, hub_sel, rmt_loop, lcl_loop;
   logic       fr_tx_bit, line_rx_bit;
   logic [7:0] fr_tx_word;
   logic       line_tx_bit, fr_rx_bit, word_clk, word_stb, word_valid, ref_sel_local;
   logic [7:0] fr_rx_word;

   line_serdes_mux u0 (
      .clk(clk), .rst_n(rst_n), .par_sel(par_sel), .wide_sel(wide_sel),
      .hub_sel(hub_sel), .rmt_loop(rmt_loop), .lcl_loop(lcl_loop),
      .fr_tx_bit(fr_tx_bit), .fr_tx_word(fr_tx_word), .line_rx_bit(line_rx_bit),
      .line_tx_bit(line_tx_bit), .fr_rx_bit(fr_rx_bit), .fr_rx_word(fr_rx_word),
      .word_clk(word_clk), .word_stb(word_stb), .word_valid(word_valid),
      .ref_sel_local(ref_sel_local)
   );

   int n_chk = 0;
   int n_err = 0;
   int cur_n = 1;
   logic [7:0] prev_tx = 8'h00;

   // {wide, rx word, tx word}
   localparam logic [16:0] VEC [8] = '{
      17'h1A53C, 17'h10180, 17'h1FF00, 17'h196E7,
      17'h0F9C6, 17'h0A45B, 17'h03FF0, 17'h16DD2
   };

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] lane_mask(input int n);
      return (n == 8) ? 8'hFF : 8'h0F;
   endfunction

   // called at a negedge; returns at the negedge after the clear edge
   task automatic set_mode(input bit par, input bit wide);
      par_sel = par; wide_sel = wide;
      @(negedge clk);
      cur_n   = !par ? 1 : (wide ? 8 : 4);
      prev_tx = 8'h00;
      chk(fr_rx_word == 8'h00, "R9 word cleared", 32'(fr_rx_word), 32'h0);
      chk(word_valid == 1'b0, "R9 valid cleared", 32'(word_valid), 32'h0);
      chk(word_stb == 1'b0, "R9 strobe cleared", 32'(word_stb), 32'h0);
   endtask

   // one word in a word mode; starts and ends at a negedge with bit counter at 0
   task automatic run_word(input logic [7:0] rxw, input logic [7:0] txw, input logic [7:0] exp_prev);
      logic [7:0] exp_rx;
      for (int k = 0; k < cur_n; k++) begin
         line_rx_bit = rxw[cur_n-1-k];
         fr_tx_word  = txw;
         @(negedge clk);
         chk(line_tx_bit == exp_prev[cur_n-1-k], "R5 tx bit order",
             32'(line_tx_bit), 32'(exp_prev[cur_n-1-k]));
         if (k < cur_n - 1) begin
            chk(word_clk == (((k + 1) % cur_n) >= cur_n / 2), "R2 word clock",
                32'(word_clk), 32'(((k + 1) % cur_n) >= cur_n / 2));
            chk(word_stb == 1'b0, "R3 strobe low mid-word", 32'(word_stb), 32'h0);
         end
      end
      exp_rx = rxw & lane_mask(cur_n);
      chk(fr_rx_word == exp_rx, "R3/R4 rx word", 32'(fr_rx_word), 32'(exp_rx));
      chk(word_stb == 1'b1, "R3 strobe at word", 32'(word_stb), 32'h1);
      chk(word_valid == 1'b1, "R9 valid after word", 32'(word_valid), 32'h1);
      chk(word_clk == 1'b0, "R2 word clock at boundary", 32'(word_clk), 32'h0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      rst_n = 1'b0; par_sel = 1'b0; wide_sel = 1'b0; hub_sel = 1'b0;
      rmt_loop = 1'b0; lcl_loop = 1'b0; fr_tx_bit = 1'b0; line_rx_bit = 1'b0;
      fr_tx_word = 8'h00;
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(line_tx_bit == 1'b0, "R10 line_tx", 32'(line_tx_bit), 32'h0);
      chk(fr_rx_bit == 1'b0, "R10 fr_rx_bit", 32'(fr_rx_bit), 32'h0);
      chk(fr_rx_word == 8'h00, "R10 fr_rx_word", 32'(fr_rx_word), 32'h0);
      chk(word_clk == 1'b0, "R10 word_clk", 32'(word_clk), 32'h0);
      chk(word_stb == 1'b0, "R10 word_stb", 32'(word_stb), 32'h0);
      chk(word_valid == 1'b0, "R10 word_valid", 32'(word_valid), 32'h0);
      rst_n = 1'b1;

      // R8 reference select over all control combinations
      for (int c = 0; c < 8; c++) begin
         hub_sel = c[0]; rmt_loop = c[1]; lcl_loop = c[2];
         #1;
         chk(ref_sel_local == (c[0] && !c[1]), "R8 ref select",
             32'(ref_sel_local), 32'(c[0] && !c[1]));
      end
      hub_sel = 1'b0; rmt_loop = 1'b0; lcl_loop = 1'b0;
      @(negedge clk);

      // R1 bit mode pass-through
      for (int i = 0; i < 12; i++) begin
         fr_tx_bit   = i[0] ^ i[2];
         line_rx_bit = i[1];
         @(negedge clk);
         chk(line_tx_bit == (i[0] ^ i[2]), "R1 serial tx", 32'(line_tx_bit), 32'(i[0] ^ i[2]));
         chk(fr_rx_bit == i[1], "R1 serial rx", 32'(fr_rx_bit), 32'(i[1]));
         chk(word_stb == 1'b1, "R1 serial strobe", 32'(word_stb), 32'h1);
         chk(word_clk == 1'b0, "R2 serial word clock low", 32'(word_clk), 32'h0);
         chk(fr_rx_word == 8'h00, "R1 serial word zero", 32'(fr_rx_word), 32'h0);
      end
      // R1 width select ignored in bit mode
      wide_sel = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk(word_valid == 1'b1, "R1 width ignored in serial", 32'(word_valid), 32'h1);
      wide_sel = 1'b0;

      // R7 local loopback active
      hub_sel = 1'b1; lcl_loop = 1'b1; line_rx_bit = 1'b0;
      for (int i = 0; i < 8; i++) begin
         fr_tx_bit = i[0] | i[2];
         @(negedge clk);
         if (i > 0)
            chk(fr_rx_bit == ((i - 1) % 2 == 1 || ((i - 1) & 4) != 0), "R7 local loop active",
                32'(fr_rx_bit), 32'((i - 1) % 2 == 1 || ((i - 1) & 4) != 0));
      end
      // R7 suppressed by hub_sel low
      hub_sel = 1'b0; fr_tx_bit = 1'b0;
      for (int i = 0; i < 6; i++) begin
         line_rx_bit = ~i[0];
         @(negedge clk);
         chk(fr_rx_bit == ~i[0], "R7 local loop off (hub low)", 32'(fr_rx_bit), 32'(~i[0]));
      end
      // R7 suppressed by remote loop, R6 bit-mode remote loop
      hub_sel = 1'b1; rmt_loop = 1'b1;
      for (int i = 0; i < 6; i++) begin
         line_rx_bit = i[0];
         fr_tx_bit   = ~i[0];
         @(negedge clk);
         chk(fr_rx_bit == i[0], "R7 local loop off (remote)", 32'(fr_rx_bit), 32'(i[0]));
         chk(line_tx_bit == i[0], "R6 serial remote loop", 32'(line_tx_bit), 32'(i[0]));
      end
      hub_sel = 1'b0; rmt_loop = 1'b0; lcl_loop = 1'b0;

      // table walk over word modes: R2 R3 R4 R5
      set_mode(1'b1, VEC[0][16]);
      for (int i = 0; i < 8; i++) begin
         if ((VEC[i][16] ? 8 : 4) != cur_n) set_mode(1'b1, VEC[i][16]);
         run_word(VEC[i][15:8], VEC[i][7:0], prev_tx);
         prev_tx = VEC[i][7:0] & lane_mask(cur_n);
      end

      // R6 remote loopback in wide mode: framer word ignored
      rmt_loop = 1'b1;
      run_word(8'hC3, 8'hFF, prev_tx);
      run_word(8'h5A, 8'h00, 8'hC3);
      rmt_loop = 1'b0;
      run_word(8'h00, 8'h81, 8'h5A);
      prev_tx = 8'h81;

      // R9 mode change in mid-word clears everything
      for (int k = 0; k < 3; k++) begin
         line_rx_bit = 1'b1;
         @(negedge clk);
      end
      set_mode(1'b1, 1'b0);
      run_word(8'h0D, 8'h0E, 8'h00);
      run_word(8'hF2, 8'hF9, 8'h0E);
      // R4 narrow upper tx inputs ignored: only lanes 3..0 go out
      run_word(8'h00, 8'h00, 8'h09);

      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule